// File: doc/BRIEF.md
# Banked Clock Fan-out with Half-Rate Select and Polarity Control

This block takes one reference clock and fans it out to a set of output banks. The default build has four banks of five outputs each. Each bank picks its own rate: either the reference clock itself or the clock divided by two. Every half-rate bank takes its clock from one shared toggle divider, so all of them run in the same phase. A two-bit polarity code sets which banks are inverted. The decode is a thermometer running up from the first bank, and the first bank is always inverted.

A single active-low master-reset/output-enable input does two jobs while it is low: it holds the divider cleared and it disables every output. During that time the internal level of each output is forced to a known value. That value is high for an inverted bank and low for a non-inverted bank. Every output is modelled as a data bit plus a drive-enable bit, which a pad ring can turn into a tri-state driver.

Top module: `banked_clkdiv`

## Requirements
- R1: While `mr_oe_n` is 0, every bit of `q_en` is 0 (high impedance), whatever the other inputs are.
- R2: While `mr_oe_n` is 0, the data bits of an inverted bank are 1 and those of a non-inverted bank are 0, on both clock phases.
- R3: The divider is held at 0 during reset. The first rising edge of `clk_ref` after release toggles it, so half-rate non-inverted outputs go high and half-rate inverted outputs go low on that edge.
- R4: A bank whose `div_sel` bit is 1 follows `clk_ref`, XORed with that bank's inversion bit.
- R5: A bank whose `div_sel` bit is 0 toggles once per `clk_ref` rising edge (half the input rate). All half-rate banks share one phase.
- R6: Inversion decode, with bank index b (A=0, B=1, C=2, D=3): bank b is inverted when b is less than or equal to the unsigned value of `inv_code`. So 00 inverts A only, 01 inverts A and B, 10 inverts A to C, and 11 inverts all four.
- R7: Bank A (bank 0) is inverted for every value of `inv_code`.
- R8: All outputs of a bank carry the same value. Output i of bank b is bit b*OUTS_PER_BANK+i of `q_dat` and `q_en`.
- R9: Any mix of full-rate and half-rate banks works at the same time.
- R10: While `mr_oe_n` is 1, every bit of `q_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| mr_oe_n | input | 1 | Active-low divider reset and output disable |
| div_sel | input | NUM_BANKS | Per-bank rate: 1 = full rate, 0 = half rate |
| inv_code | input | POL_W | Thermometer polarity code |
| q_dat | output | NUM_BANKS*OUTS_PER_BANK | Output data levels, grouped by bank |
| q_en | output | NUM_BANKS*OUTS_PER_BANK | Output drive enables, grouped by bank |

## Verification
The bench builds the block with its defaults: four banks of five outputs and a two-bit polarity code. At that size every rate-select pattern and every polarity code can be swept exhaustively, which gives 64 combinations. Each combination is entered under reset and then released. The outputs are then sampled in both clock phases over four input cycles. This reaches the forced reset levels, the first-edge divider phase, the mixed-rate cases and every step of the thermometer decode.

// File: rtl/banked_clkdiv_pkg.sv
package banked_clkdiv_pkg;

   // thermometer polarity: bank index at or below the code is inverted,
   // the first bank is inverted unconditionally
   function automatic logic therm_hit(input int bank, input int code);
      return (bank == 0) || (bank <= code);
   endfunction

endpackage

// File: rtl/bcd_toggle_div.sv
module bcd_toggle_div (
   input  logic clk_ref,
   input  logic rst_n,
   output logic half_clk
);
   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) half_clk <= 1'b0;
      else        half_clk <= ~half_clk;
   end
endmodule

// File: rtl/bcd_pol_decode.sv
module bcd_pol_decode #(
   parameter int NUM_BANKS = 4,
   parameter int POL_W     = 2
) (
   input  logic [POL_W-1:0]     code,
   output logic [NUM_BANKS-1:0] inv
);
   import banked_clkdiv_pkg::*;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign inv[b] = therm_hit(b, int'(code));
   end
endmodule

// File: rtl/bcd_bank_mux.sv
module bcd_bank_mux #(
   parameter int OUTS_PER_BANK = 5
) (
   input  logic                     clk_ref,
   input  logic                     half_clk,
   input  logic                     rst_n,
   input  logic                     full_rate,
   input  logic                     invert,
   output logic [OUTS_PER_BANK-1:0] dat,
   output logic [OUTS_PER_BANK-1:0] en
);
   logic rate_clk;
   logic level;

   assign rate_clk = full_rate ? clk_ref : half_clk;
   // reset forces the non-inverted level low, hence the inverted level high
   assign level    = rst_n ? (rate_clk ^ invert) : invert;

   for (genvar i = 0; i < OUTS_PER_BANK; i++) begin : g_out
      assign dat[i] = level;
      assign en[i]  = rst_n;
   end
endmodule

// File: rtl/banked_clkdiv.sv
module banked_clkdiv #(
   parameter int NUM_BANKS     = 4,
   parameter int OUTS_PER_BANK = 5,
   parameter int POL_W         = 2
) (
   input  logic                               clk_ref,
   input  logic                               mr_oe_n,
   input  logic [NUM_BANKS-1:0]               div_sel,
   input  logic [POL_W-1:0]                   inv_code,
   output logic [NUM_BANKS*OUTS_PER_BANK-1:0] q_dat,
   output logic [NUM_BANKS*OUTS_PER_BANK-1:0] q_en
);
   localparam int CODES = 1 << POL_W;

   if (NUM_BANKS < 1) begin : g_err_banks
      $error("banked_clkdiv: NUM_BANKS must be at least 1");
   end
   if (OUTS_PER_BANK < 1) begin : g_err_outs
      $error("banked_clkdiv: OUTS_PER_BANK must be at least 1");
   end
   if (POL_W < 1 || CODES < NUM_BANKS) begin : g_err_pol
      $error("banked_clkdiv: POL_W too narrow to reach every bank");
   end

   logic                 half_clk;
   logic [NUM_BANKS-1:0] bank_inv;

   bcd_toggle_div u_div (
      .clk_ref  (clk_ref),
      .rst_n    (mr_oe_n),
      .half_clk (half_clk)
   );

   bcd_pol_decode #(
      .NUM_BANKS (NUM_BANKS),
      .POL_W     (POL_W)
   ) u_pol (
      .code (inv_code),
      .inv  (bank_inv)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      bcd_bank_mux #(
         .OUTS_PER_BANK (OUTS_PER_BANK)
      ) u_mux (
         .clk_ref   (clk_ref),
         .half_clk  (half_clk),
         .rst_n     (mr_oe_n),
         .full_rate (div_sel[b]),
         .invert    (bank_inv[b]),
         .dat       (q_dat[b*OUTS_PER_BANK +: OUTS_PER_BANK]),
         .en        (q_en[b*OUTS_PER_BANK +: OUTS_PER_BANK])
      );
   end
endmodule

// File: rtl/banked_clkdiv_chk.sv
module banked_clkdiv_chk #(
   parameter int NUM_BANKS     = 4,
   parameter int OUTS_PER_BANK = 5,
   parameter int POL_W         = 2
) (
   input logic                               clk_ref,
   input logic                               mr_oe_n,
   input logic [NUM_BANKS-1:0]               div_sel,
   input logic [POL_W-1:0]                   inv_code,
   input logic [NUM_BANKS*OUTS_PER_BANK-1:0] q_dat,
   input logic [NUM_BANKS*OUTS_PER_BANK-1:0] q_en
);
   localparam int OPB = OUTS_PER_BANK;

   // R1: outputs released while reset is held
   always_comb begin
      if (mr_oe_n == 1'b0) begin
         a_r1_hiz : assert (q_en == '0) else $error("R1 enable seen in reset");
      end
   end

   // R2 / R7: bank A sits at its inverted level during reset
   always_comb begin
      if (mr_oe_n == 1'b0) begin
         a_r2_bank_a_high : assert (q_dat[OPB-1:0] == '1) else $error("R2 bank A level in reset");
      end
   end

   // R10
   a_r10_enabled : assert property (@(negedge clk_ref) disable iff (!mr_oe_n)
      q_en == '1);

   // R7: values sampled just before a falling edge belong to the high phase
   a_r7_bank_a_inv : assert property (@(negedge clk_ref) disable iff (!mr_oe_n)
      div_sel[0] |-> q_dat[OPB-1:0] == '0);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      // R8
      a_r8_uniform : assert property (@(negedge clk_ref) disable iff (!mr_oe_n)
         (q_dat[b*OPB +: OPB] == '0) || (q_dat[b*OPB +: OPB] == '1));

      // R5: one toggle per input period while half rate is held
      a_r5_half_toggle : assert property (@(negedge clk_ref) disable iff (!mr_oe_n)
         (!div_sel[b] && $past(!div_sel[b]) && $past(mr_oe_n) && $stable(inv_code))
         |-> q_dat[b*OPB] != $past(q_dat[b*OPB]));
   end
endmodule

bind banked_clkdiv banked_clkdiv_chk #(
   .NUM_BANKS     (NUM_BANKS),
   .OUTS_PER_BANK (OUTS_PER_BANK),
   .POL_W         (POL_W)
) u_chk (
   .clk_ref  (clk_ref),
   .mr_oe_n  (mr_oe_n),
   .div_sel  (div_sel),
   .inv_code (inv_code),
   .q_dat    (q_dat),
   .q_en     (q_en)
);

// File: tb/banked_clkdiv_tb.sv
`timescale 1ns/1ps
module banked_clkdiv_tb;
   localparam int NB  = 4;
   localparam int OPB = 5;
   localparam int PW  = 2;
   localparam int NQ  = NB*OPB;

   logic          clk_ref = 1'b0;
   logic          mr_oe_n = 1'b0;
   logic [NB-1:0] div_sel = '1;
   logic [PW-1:0] inv_code = '1;
   logic [NQ-1:0] q_dat;
   logic [NQ-1:0] q_en;

   banked_clkdiv #(.NUM_BANKS(NB), .OUTS_PER_BANK(OPB), .POL_W(PW)) u_dut (
      .clk_ref  (clk_ref),
      .mr_oe_n  (mr_oe_n),
      .div_sel  (div_sel),
      .inv_code (inv_code),
      .q_dat    (q_dat),
      .q_en     (q_en)
   );

   always #10 clk_ref = ~clk_ref;  // 50 MHz

   typedef struct {
      string         tag;
      logic [NQ-1:0] exp;
      bit            is_en;
   } item_t;

   item_t sbq[$];
   event  smp_ev;
   int    n_vec = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   logic  div_m = 1'b0;

   // monitor: pops expected items and compares with the ports
   initial begin
      item_t         it;
      logic [NQ-1:0] got;
      forever begin
         @(smp_ev);
         while (sbq.size() > 0) begin
            it  = sbq.pop_front();
            got = it.is_en ? q_en : q_dat;
            n_vec++;
            if (got !== it.exp) begin
               n_bad++;
               $display("FAIL %s %s got %h exp %h", it.tag,
                        it.is_en ? "enable" : "data", got, it.exp);
            end
         end
      end
   end

   // expected inversion per R6/R7
   function automatic logic inv_of(input int b, input logic [PW-1:0] code);
      return (b == 0) || (b <= int'(code));
   endfunction

   function automatic logic [NQ-1:0] exp_dat(input logic clkv, input logic divv,
                                             input logic in_rst);
      logic [NQ-1:0] v;
      for (int b = 0; b < NB; b++) begin
         logic lvl;
         if (in_rst) lvl = inv_of(b, inv_code);
         else        lvl = (div_sel[b] ? clkv : divv) ^ inv_of(b, inv_code);
         for (int i = 0; i < OPB; i++) v[b*OPB+i] = lvl;
      end
      return v;
   endfunction

   task automatic push(input string tag, input logic [NQ-1:0] exp, input bit is_en);
      item_t it;
      it.tag = tag; it.exp = exp; it.is_en = is_en;
      sbq.push_back(it);
   endtask

   task automatic fire();
      -> smp_ev;
      #1;
   endtask

   task automatic check_reset(input logic clkv);
      push("R1", '0, 1'b1);
      push("R2", exp_dat(clkv, 1'b0, 1'b1), 1'b0);
      fire();
   endtask

   task automatic run_combo(input logic [NB-1:0] sel, input logic [PW-1:0] code);
      @(negedge clk_ref); #5;
      mr_oe_n  = 1'b0;
      div_sel  = sel;
      inv_code = code;
      #1 check_reset(1'b0);
      @(posedge clk_ref); #5;
      check_reset(1'b1);
      @(negedge clk_ref); #5;
      mr_oe_n = 1'b1;
      div_m   = 1'b0;
      for (int c = 0; c < 4; c++) begin
         @(posedge clk_ref);
         div_m = ~div_m;
         #5;
         push("R10", '1, 1'b1);
         // R3 first edge after release; R4 R5 R6 R7 R8 R9 steady running
         push(c == 0 ? "R3" : "R4 R5 R6 R7 R8 R9", exp_dat(1'b1, div_m, 1'b0), 1'b0);
         fire();
         @(negedge clk_ref); #5;
         push("R10", '1, 1'b1);
         push("R4 R5 R6 R7 R8 R9", exp_dat(1'b0, div_m, 1'b0), 1'b0);
         fire();
      end
   endtask

   initial begin
      // reset state with inputs at their undriven defaults: all banks inverted
      repeat (3) @(negedge clk_ref);
      #5 check_reset(1'b0);
      for (int code = 0; code < (1 << PW); code++) begin
         for (int sel = 0; sel < (1 << NB); sel++) begin
            run_combo(NB'(sel), PW'(code));
         end
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_bad++;
         $display("FAIL all watchdog got timeout exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule